// File: doc/BRIEF.md
# Per-Port Receive FIFO Status Selector

This block supplies the 2-bit receive buffer status that a calendar-driven status channel sends for each port. A frame sequencer presents a port number together with a request strobe. One clock later the block returns a status word and a valid strobe. The word comes from one of two sources. The first is a threshold calculator, which compares a buffer fill level against that port's almost-empty and almost-full thresholds. The second is a hold memory, which user logic writes through an address/value/valid interface.

Two inputs choose the source. In individual-buffers mode (`shared_mode_i` low) the calculated status is always used. In shared-buffer mode (`shared_mode_i` high) the calculator uses one common fill level for every port. In that mode `user_src_i` picks the held value (high) or the calculated value (low).

An overflow in either the clock-crossing buffer or the data buffer moves the overflow FSM from state OVF_IDLE to state OVF_FORCED (transition SET). While the FSM is in OVF_FORCED, every returned status is satisfied. A pulse on `ovf_clr_i` with no overflow present in the same cycle returns the FSM to OVF_IDLE (transition CLEAR).

Top module: `fifo_status_select`

## Requirements
- R1: After reset `stat_vld_o` is low and every hold memory entry reads as satisfied (2'b10).
- R2: `stat_vld_o` is high in exactly the cycle after each cycle in which `req_i` is high, and low at all other times.
- R3: The calculated status of port p is starving (2'b00) when its level is at or below `ae_thr_i[p]`. It is satisfied (2'b10) when its level is at or above `af_thr_i[p]`. Otherwise it is hungry (2'b01). Port p uses the fields `[p*LEVEL_W +: LEVEL_W]`.
- R4: In shared-buffer mode the calculator uses `shared_fill_i` for every port, with each port's own thresholds.
- R5: In individual-buffers mode the calculated status is returned whatever the value of `user_src_i`.
- R6: In shared-buffer mode with `user_src_i` high, the status returned is the hold memory entry at the requested port.
- R7: The hold memory is written on every cycle in which `ext_wr_vld_i` is high, and addresses may come in any order. The last write wins. A cycle with `ext_wr_vld_i` low writes nothing.
- R8: A write to an address at or above NUM_PORTS does not change the status returned for any provisioned port.
- R9: A request and a write to the same address in the same cycle return the value held before the write.
- R10: An overflow pulse on `ovf_cdc_i` or `ovf_buf_i` forces satisfied for every request made from the next cycle on, in every mode. The force lasts until `ovf_clr_i` is pulsed. If a clear and an overflow arrive in the same cycle, the overflow wins.
- R11: The calculator never produces the reserved code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shared_mode_i | input | 1 | 1 = shared-buffer mode, 0 = individual buffers |
| user_src_i | input | 1 | In shared mode, 1 = use the hold memory |
| req_i | input | 1 | Status request strobe |
| req_port_i | input | PORT_W | Requested port |
| fill_lvl_i | input | NUM_PORTS*LEVEL_W | Per-port fill levels |
| shared_fill_i | input | LEVEL_W | Common fill level used in shared mode |
| ae_thr_i | input | NUM_PORTS*LEVEL_W | Per-port almost-empty thresholds |
| af_thr_i | input | NUM_PORTS*LEVEL_W | Per-port almost-full thresholds |
| ext_wr_vld_i | input | 1 | Hold memory write strobe |
| ext_wr_addr_i | input | PORT_W | Hold memory write address |
| ext_wr_stat_i | input | 2 | Status value to write |
| ovf_cdc_i | input | 1 | Clock-crossing buffer overflow pulse |
| ovf_buf_i | input | 1 | Data buffer overflow pulse |
| ovf_clr_i | input | 1 | Clears the sticky overflow force |
| stat_vld_o | output | 1 | Status word valid |
| stat_o | output | 2 | Status word |

## Verification
A corrupted hold memory entry shows only when that port is requested in user-source mode. It then appears in the word one clock after the request, so the bench reads back every provisioned port after each group of writes. If the overflow FSM sits in the wrong state, the next request in any mode returns satisfied when it should not, or a non-forced value when it should be forced. Each set and clear is therefore followed directly by a request. A wrong source select or threshold compare shows in the first response for a port whose level sits on a threshold boundary, so those boundary levels are requested explicitly.

// File: rtl/fss_pkg.sv
package fss_pkg;
    typedef enum logic [1:0] {
        ST_STARVE = 2'b00,
        ST_HUNGRY = 2'b01,
        ST_SATIS  = 2'b10,
        ST_RSVD   = 2'b11
    } fifo_stat_e;

    typedef enum logic {
        OVF_IDLE,
        OVF_FORCED
    } ovf_state_e;
endpackage

// File: rtl/fss_calc.sv
module fss_calc
    import fss_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    parameter int LEVEL_W   = 8
) (
    input  logic                           shared_i,
    input  logic [PORT_W-1:0]              port_i,
    input  logic [NUM_PORTS*LEVEL_W-1:0]   fill_vec_i,
    input  logic [LEVEL_W-1:0]             shared_fill_i,
    input  logic [NUM_PORTS*LEVEL_W-1:0]   ae_vec_i,
    input  logic [NUM_PORTS*LEVEL_W-1:0]   af_vec_i,
    output logic [1:0]                     stat_o
);
    fifo_stat_e per_stat [NUM_PORTS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [LEVEL_W-1:0] lvl;
        logic [LEVEL_W-1:0] ae;
        logic [LEVEL_W-1:0] af;
        assign lvl = shared_i ? shared_fill_i : fill_vec_i[p*LEVEL_W +: LEVEL_W];
        assign ae  = ae_vec_i[p*LEVEL_W +: LEVEL_W];
        assign af  = af_vec_i[p*LEVEL_W +: LEVEL_W];
        always_comb begin
            if (lvl <= ae)      per_stat[p] = ST_STARVE;
            else if (lvl >= af) per_stat[p] = ST_SATIS;
            else                per_stat[p] = ST_HUNGRY;
        end
    end

    always_comb begin
        stat_o = ST_SATIS;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_i == PORT_W'(p)) stat_o = per_stat[p];
        end
    end
endmodule

// File: rtl/fss_hold_ram.sv
module fss_hold_ram
    import fss_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_addr,
    input  logic [1:0]        wr_data,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] rd_addr,
    output logic [1:0]        rd_data
);
    localparam int DEPTH = 1 << PORT_W;

    logic [1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ST_SATIS;
            rd_data <= ST_SATIS;
        end else begin
            if (rd_en) rd_data <= mem[rd_addr];
            if (wr_en) mem[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/fss_ovf_fsm.sv
module fss_ovf_fsm
    import fss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_a_i,
    input  logic ovf_b_i,
    input  logic clr_i,
    output logic forced_o
);
    ovf_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OVF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        forced_o = 1'b0;
        unique case (state_q)
            OVF_IDLE: begin
                if (ovf_a_i || ovf_b_i) state_d = OVF_FORCED;
            end
            OVF_FORCED: begin
                forced_o = 1'b1;
                if (clr_i && !ovf_a_i && !ovf_b_i) state_d = OVF_IDLE;
            end
            default: state_d = OVF_IDLE;
        endcase
    end
endmodule

// File: rtl/fifo_status_select.sv
module fifo_status_select
    import fss_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    parameter int LEVEL_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         shared_mode_i,
    input  logic                         user_src_i,
    input  logic                         req_i,
    input  logic [PORT_W-1:0]            req_port_i,
    input  logic [NUM_PORTS*LEVEL_W-1:0] fill_lvl_i,
    input  logic [LEVEL_W-1:0]           shared_fill_i,
    input  logic [NUM_PORTS*LEVEL_W-1:0] ae_thr_i,
    input  logic [NUM_PORTS*LEVEL_W-1:0] af_thr_i,
    input  logic                         ext_wr_vld_i,
    input  logic [PORT_W-1:0]            ext_wr_addr_i,
    input  logic [1:0]                   ext_wr_stat_i,
    input  logic                         ovf_cdc_i,
    input  logic                         ovf_buf_i,
    input  logic                         ovf_clr_i,
    output logic                         stat_vld_o,
    output logic [1:0]                   stat_o
);
    logic [1:0] calc_stat;
    logic [1:0] hold_stat;
    logic       ovf_forced;
    logic       use_hold;

    logic       vld_q;
    logic       use_hold_q;
    logic       force_q;
    logic [1:0] calc_q;

    assign use_hold = shared_mode_i & user_src_i;

    fss_calc #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W),
        .LEVEL_W   (LEVEL_W)
    ) u_calc (
        .shared_i      (shared_mode_i),
        .port_i        (req_port_i),
        .fill_vec_i    (fill_lvl_i),
        .shared_fill_i (shared_fill_i),
        .ae_vec_i      (ae_thr_i),
        .af_vec_i      (af_thr_i),
        .stat_o        (calc_stat)
    );

    fss_hold_ram #(
        .PORT_W (PORT_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ext_wr_vld_i),
        .wr_addr (ext_wr_addr_i),
        .wr_data (ext_wr_stat_i),
        .rd_en   (req_i),
        .rd_addr (req_port_i),
        .rd_data (hold_stat)
    );

    fss_ovf_fsm u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovf_a_i  (ovf_cdc_i),
        .ovf_b_i  (ovf_buf_i),
        .clr_i    (ovf_clr_i),
        .forced_o (ovf_forced)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q      <= 1'b0;
            use_hold_q <= 1'b0;
            force_q    <= 1'b0;
            calc_q     <= ST_SATIS;
        end else begin
            vld_q <= req_i;
            if (req_i) begin
                use_hold_q <= use_hold;
                force_q    <= ovf_forced;
                calc_q     <= calc_stat;
            end
        end
    end

    always_comb begin
        if (force_q)         stat_o = ST_SATIS;
        else if (use_hold_q) stat_o = hold_stat;
        else                 stat_o = calc_q;
    end

    assign stat_vld_o = vld_q;
endmodule

// File: rtl/fss_checker.sv
module fss_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_i,
    input logic       shared_mode_i,
    input logic       user_src_i,
    input logic       ovf_cdc_i,
    input logic       ovf_buf_i,
    input logic       ovf_clr_i,
    input logic       ovf_forced,
    input logic       stat_vld_o,
    input logic [1:0] stat_o
);
    a_r2_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> stat_vld_o);

    a_r2_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !stat_vld_o);

    a_r11_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !(shared_mode_i && user_src_i)) |=> (stat_o != 2'b11));

    a_r10_forced_satisfied: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ovf_forced) |=> (stat_o == 2'b10));

    a_r10_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cdc_i || ovf_buf_i) |=> ovf_forced);

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_forced && !ovf_clr_i) |=> ovf_forced);

    a_r10_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr_i && !ovf_cdc_i && !ovf_buf_i) |=> !ovf_forced);
endmodule

bind fifo_status_select fss_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .shared_mode_i (shared_mode_i),
    .user_src_i    (user_src_i),
    .ovf_cdc_i     (ovf_cdc_i),
    .ovf_buf_i     (ovf_buf_i),
    .ovf_clr_i     (ovf_clr_i),
    .ovf_forced    (ovf_forced),
    .stat_vld_o    (stat_vld_o),
    .stat_o        (stat_o)
);

// File: tb/fifo_status_select_tb.sv
`timescale 1ns/1ps
module fifo_status_select_tb;
    localparam int NP = 4;
    localparam int PW = 8;
    localparam int LW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            shared_mode = 1'b0;
    logic            user_src = 1'b0;
    logic            req = 1'b0;
    logic [PW-1:0]   req_port = '0;
    logic [NP*LW-1:0] fill_vec = '0;
    logic [LW-1:0]   shared_fill = '0;
    logic [NP*LW-1:0] ae_vec = '0;
    logic [NP*LW-1:0] af_vec = '0;
    logic            wr_vld = 1'b0;
    logic [PW-1:0]   wr_addr = '0;
    logic [1:0]      wr_stat = '0;
    logic            ovf_cdc = 1'b0;
    logic            ovf_buf = 1'b0;
    logic            ovf_clr = 1'b0;
    logic            stat_vld;
    logic [1:0]      stat;

    int checks = 0;
    int errors = 0;
    int ae_a [NP];
    int af_a [NP];
    int fill_a [NP];

    logic [1:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    fifo_status_select #(.NUM_PORTS(NP), .PORT_W(PW), .LEVEL_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .shared_mode_i(shared_mode), .user_src_i(user_src),
        .req_i(req), .req_port_i(req_port), .fill_lvl_i(fill_vec),
        .shared_fill_i(shared_fill), .ae_thr_i(ae_vec), .af_thr_i(af_vec),
        .ext_wr_vld_i(wr_vld), .ext_wr_addr_i(wr_addr), .ext_wr_stat_i(wr_stat),
        .ovf_cdc_i(ovf_cdc), .ovf_buf_i(ovf_buf), .ovf_clr_i(ovf_clr),
        .stat_vld_o(stat_vld), .stat_o(stat)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // starving 0 / hungry 1 / satisfied 2, from the threshold rule
    function automatic logic [1:0] ref_stat(input int lvl, input int ae, input int af);
        if (lvl <= ae) return 2'b00;
        if (lvl >= af) return 2'b10;
        return 2'b01;
    endfunction

    task automatic apply_levels();
        for (int p = 0; p < NP; p++) begin
            fill_vec[p*LW +: LW] = LW'(fill_a[p]);
            ae_vec[p*LW +: LW]   = LW'(ae_a[p]);
            af_vec[p*LW +: LW]   = LW'(af_a[p]);
        end
    endtask

    task automatic do_req(input int port, input logic [1:0] exp, input string tag);
        @(negedge clk);
        req = 1'b1;
        req_port = PW'(port);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic do_write(input int addr, input logic [1:0] val, input logic vld);
        @(negedge clk);
        wr_vld = vld;
        wr_addr = PW'(addr);
        wr_stat = val;
        @(negedge clk);
        wr_vld = 1'b0;
    endtask

    // monitor: pops the scoreboard whenever a status is presented
    always @(negedge clk) begin
        if (rst_n && stat_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected valid", 1, 0);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(stat == e, t, stat, e);
            end
        end
    end

    initial begin
        #(8 * 50000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            ae_a[p] = 10 + 10 * p;
            af_a[p] = 50 + 10 * p;
            fill_a[p] = 0;
        end
        apply_levels();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(stat_vld == 1'b0, "R1 valid low after reset", stat_vld, 0);

        // R1: hold memory starts satisfied
        shared_mode = 1'b1; user_src = 1'b1;
        for (int p = 0; p < NP; p++) do_req(p, 2'b10, "R1 hold reset value");

        // R3: individual mode, boundary levels
        shared_mode = 1'b0; user_src = 1'b0;
        fill_a[0] = 10; fill_a[1] = 21; fill_a[2] = 70; fill_a[3] = 79;
        apply_levels();
        for (int p = 0; p < NP; p++)
            do_req(p, ref_stat(fill_a[p], ae_a[p], af_a[p]), "R3 threshold compare");
        fill_a[0] = 11; apply_levels(); do_req(0, 2'b01, "R3 just above almost-empty");
        fill_a[0] = 50; apply_levels(); do_req(0, 2'b10, "R3 at almost-full");
        fill_a[0] = 49; apply_levels(); do_req(0, 2'b01, "R3 just below almost-full");
        fill_a[0] = 0;  apply_levels(); do_req(0, 2'b00, "R3 empty");

        // R5: user source ignored in individual mode
        user_src = 1'b1;
        for (int p = 0; p < NP; p++)
            do_req(p, ref_stat(fill_a[p], ae_a[p], af_a[p]), "R5 calc in individual mode");

        // R4: shared fill level
        shared_mode = 1'b1; user_src = 1'b0;
        shared_fill = 8'd30;
        for (int p = 0; p < NP; p++)
            do_req(p, ref_stat(30, ae_a[p], af_a[p]), "R4 shared level 30");
        shared_fill = 8'd60;
        for (int p = 0; p < NP; p++)
            do_req(p, ref_stat(60, ae_a[p], af_a[p]), "R4 shared level 60");

        // R6/R7/R8: user-written hold memory
        user_src = 1'b1;
        do_write(3, 2'b00, 1'b1);
        do_write(0, 2'b00, 1'b1);
        do_write(2, 2'b00, 1'b1);
        do_write(2, 2'b01, 1'b1);
        do_write(1, 2'b00, 1'b0);
        do_write(200, 2'b01, 1'b1);
        do_req(0, 2'b00, "R6 held port0");
        do_req(1, 2'b10, "R7 valid-low write ignored / R8");
        do_req(2, 2'b01, "R7 last write wins");
        do_req(3, 2'b00, "R6 held port3");

        // R9: same-cycle read and write
        @(negedge clk);
        req = 1'b1; req_port = 8'd0;
        wr_vld = 1'b1; wr_addr = 8'd0; wr_stat = 2'b01;
        exp_q.push_back(2'b00); tag_q.push_back("R9 read-before-write");
        @(negedge clk);
        req = 1'b0; wr_vld = 1'b0;
        do_req(0, 2'b01, "R9 new value visible");

        // R10: overflow from the clock-crossing buffer
        @(negedge clk); ovf_cdc = 1'b1;
        @(negedge clk); ovf_cdc = 1'b0;
        do_req(0, 2'b10, "R10 forced user mode");
        repeat (5) @(negedge clk);
        do_req(3, 2'b10, "R10 still forced");
        shared_mode = 1'b0; user_src = 1'b0;
        do_req(0, 2'b10, "R10 forced individual mode");
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        do_req(0, 2'b00, "R10 released after clear");

        // R10: data buffer overflow, and clear colliding with overflow
        shared_mode = 1'b1; user_src = 1'b1;
        @(negedge clk); ovf_buf = 1'b1;
        @(negedge clk); ovf_buf = 1'b0;
        do_req(3, 2'b10, "R10 forced by data buffer");
        @(negedge clk); ovf_clr = 1'b1; ovf_cdc = 1'b1;
        @(negedge clk); ovf_clr = 1'b0; ovf_cdc = 1'b0;
        do_req(3, 2'b10, "R10 overflow wins over clear");
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        do_req(3, 2'b00, "R10 released");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule